// File: doc/BRIEF.md
# Halfword Instruction Fetch Queue

This block sits between a 32-bit instruction memory port and a decoder that handles a mix of 16-bit and 32-bit instructions. It fetches aligned 32-bit words through a request/ready/valid handshake whose response latency may vary. It holds up to three words and keeps asking for more while space remains. From the oldest stored word it cuts out the next instruction, which is either one halfword or two halfwords. Those two halfwords may lie in two neighbouring words.

A halfword offset into the head word records how far decoding has reached. A branch empties the queue and restarts fetching at a new halfword-aligned target. Responses to requests made before the branch are counted and thrown away when they arrive, so the memory side never has to cancel anything.

Top module: `hw_fetch_queue`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `dec_valid_o` is 0. After reset, `mem_req_o` is 1 with `mem_addr_o` equal to the word-aligned `RESET_ADDR`.
- R2: Every accepted request (`mem_req_o` and `mem_rdy_i` both 1) carries an address with bits [1:0] equal to 0. After a branch, the first accepted address is the target with bits [1:0] cleared, and each later accepted address is 4 above the one before. The address stays stable while a request waits for `mem_rdy_i`.
- R3: The words held plus the kept requests still in flight never exceed three. With the decoder stalled, exactly three requests are accepted after a branch, and then `mem_req_o` falls to 0.
- R4: A halfword whose bits [15:11] are not 11101, 11110 or 11111 issues alone with `dec_wide_o`=0 and `dec_instr_o`={16'h0, halfword}. Within a word, bits [15:0] come before bits [31:16].
- R5: A halfword whose bits [15:11] are 11101, 11110 or 11111 issues together with the following halfword, with `dec_wide_o`=1 and `dec_instr_o`={first halfword, second halfword}.
- R6: A 32-bit instruction that starts in bits [31:16] of a word keeps `dec_valid_o` at 0 until the following word has arrived.
- R7: After a branch, `dec_valid_o` is 0 in the next cycle. No data from requests accepted before the branch is ever issued.
- R8: A branch whose target has address bit 1 set begins issue at bits [31:16] of the target word.
- R9: `dec_valid_o` is 0 in any cycle where `br_valid_i` is 1, and no instruction is consumed in that cycle.
- R10: While `dec_valid_o` is 1 and `dec_ready_i` is 0 with no branch, the issued instruction and its width stay unchanged in the next cycle and remain valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | 32 | Word-aligned fetch address |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Response data valid, in request order |
| mem_rdata_i | input | 32 | Response word |
| br_valid_i | input | 1 | Taken branch: flush and redirect |
| br_addr_i | input | 31 | Branch target, address bits [31:1] |
| dec_valid_o | output | 1 | An instruction is presented |
| dec_wide_o | output | 1 | Presented instruction is 32-bit |
| dec_instr_o | output | 32 | Presented instruction |
| dec_ready_i | input | 1 | Decoder consumes the presented instruction |

## Verification
The assertions assume that the memory answers each accepted request exactly once, in order, and at least one cycle after accepting it. They also assume that it never raises `mem_rvalid_i` when nothing is outstanding. The bench memory model keeps to this. It queues each accepted address with a due cycle, varies the latency and the ready pattern, and only ever answers the oldest entry. It keeps answering stale requests after a branch, so the block's own discard logic is exercised. Branches are issued while responses are still in flight.

// File: rtl/hw_fetch_queue.sv
module hw_fetch_queue #(
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000,
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rdy_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        br_valid_i,
  input  logic [31:1] br_addr_i,
  output logic        dec_valid_o,
  output logic        dec_wide_o,
  output logic [31:0] dec_instr_o,
  input  logic        dec_ready_i
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(2 * DEPTH + 2) + 1;
  localparam logic [CW-1:0] DEP = CW'(DEPTH);

  logic [31:0]   q [DEPTH];
  logic [PW-1:0] hp, nxt, tidx;
  logic [CW-1:0] cnt, oc, drop, live, tsum;
  logic          hoff;
  logic [31:0]   fa;
  logic [15:0]   lo, hi;
  logic          wide, have, fire, pop, acc, keep;

  assign nxt  = (hp == PW'(DEPTH - 1)) ? '0 : hp + 1'b1;
  assign tsum = CW'(hp) + cnt;
  assign tidx = (tsum >= DEP) ? PW'(tsum - DEP) : PW'(tsum);

  assign lo   = hoff ? q[hp][31:16] : q[hp][15:0];
  assign hi   = hoff ? q[nxt][15:0] : q[hp][31:16];
  assign wide = (lo[15:13] == 3'b111) && (lo[12:11] != 2'b00);
  assign have = (cnt != '0) && (!wide || !hoff || cnt >= CW'(2));

  assign dec_valid_o = have && !br_valid_i;
  assign dec_wide_o  = wide;
  assign dec_instr_o = wide ? {lo, hi} : {16'h0000, lo};

  assign fire = dec_valid_o && dec_ready_i;
  assign pop  = fire && (hoff || wide);

  assign live       = oc - drop;
  assign mem_req_o  = !br_valid_i && ((cnt + live) < DEP);
  assign mem_addr_o = fa;
  assign acc        = mem_req_o && mem_rdy_i;
  assign keep       = mem_rvalid_i && (drop == '0) && !br_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      oc   <= '0;
      drop <= '0;
      hp   <= '0;
      hoff <= RESET_ADDR[1];
      fa   <= {RESET_ADDR[31:2], 2'b00};
    end else begin
      oc <= oc + CW'(acc) - CW'(mem_rvalid_i);
      if (br_valid_i) begin
        cnt  <= '0;
        hp   <= '0;
        hoff <= br_addr_i[1];
        fa   <= {br_addr_i[31:2], 2'b00};
        drop <= oc - CW'(mem_rvalid_i);
      end else begin
        if (acc) fa <= fa + 32'd4;
        cnt <= cnt + CW'(keep) - CW'(pop);
        if (pop) hp <= nxt;
        if (fire) hoff <= hoff ^ ~wide;
        if (mem_rvalid_i && drop != '0) drop <= drop - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (keep) q[tidx] <= mem_rdata_i;
  end

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> mem_addr_o == $past(mem_addr_o) + 32'd4);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i && !br_valid_i) |=> $stable(mem_addr_o));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt + oc - drop) <= DEP);

  a_r3_resp_expected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid_i |-> oc != '0);

  a_r6_straddle: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && dec_wide_o && hoff) |-> cnt >= CW'(2));

  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i |=> !dec_valid_o);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_ready_i) |=>
      (br_valid_i || (dec_valid_o && $stable(dec_instr_o) && $stable(dec_wide_o))));
endmodule

// File: tb/hw_fetch_queue_tb.sv
module hw_fetch_queue_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_rdy, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        br_valid;
  logic [31:1] br_addr;
  logic        dec_valid, dec_wide, dec_ready;
  logic [31:0] dec_instr;

  typedef struct packed { logic wide; logic [31:0] ins; } exp_t;
  typedef struct { logic [31:0] a; int due; } pend_t;

  exp_t  expq[$];
  pend_t pend[$];
  int total = 0, bad = 0;
  int cyc = 0, budget = 1000000, lat_mode = 0, acc_since = 0;
  logic [31:0] next_fa = 32'h0;
  string cur_tag = "R4";

  always #(PERIOD/2) clk = ~clk;

  hw_fetch_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdy_i(mem_rdy),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .br_valid_i(br_valid), .br_addr_i(br_addr),
    .dec_valid_o(dec_valid), .dec_wide_o(dec_wide), .dec_instr_o(dec_instr),
    .dec_ready_i(dec_ready)
  );

  function automatic logic [15:0] hw(input logic [31:0] a);
    logic [30:0] k;
    logic [4:0] top;
    k = a[31:1];
    case (k % 6)
      0: top = 5'b11101;
      1: top = 5'b00110;
      2: top = 5'b11100;
      3: top = 5'b11110;
      4: top = 5'b01010;
      default: top = 5'b11111;
    endcase
    return {top, k[10:0] ^ 11'h2a5};
  endfunction

  function automatic logic [31:0] word(input logic [31:0] a);
    return {hw(a + 32'd2), hw(a)};
  endfunction

  function automatic bit is_wide(input logic [15:0] h);
    return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) || (h[15:11] == 5'b11111);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push_walk(input logic [31:0] start, input int n);
    logic [31:0] a;
    logic [15:0] h;
    a = start;
    for (int i = 0; i < n; i++) begin
      h = hw(a);
      if (is_wide(h)) begin
        expq.push_back({1'b1, h, hw(a + 32'd2)});
        a = a + 32'd4;
      end else begin
        expq.push_back({1'b0, 16'h0000, h});
        a = a + 32'd2;
      end
    end
  endtask

  task automatic do_branch(input logic [31:0] tgt, input int n);
    @(negedge clk);
    br_valid = 1'b1;
    br_addr  = tgt[31:1];
    next_fa  = {tgt[31:2], 2'b00};
    acc_since = 0;
    expq.delete();
    push_walk(tgt, n);
    #2;
    chk(dec_valid == 1'b0, "R9", {31'h0, dec_valid}, 32'h0);
    @(negedge clk);
    br_valid = 1'b0;
    #2;
    chk(dec_valid == 1'b0, "R7", {31'h0, dec_valid}, 32'h0);
  endtask

  task automatic drain(input int mode);
    int i;
    i = 0;
    forever begin
      @(negedge clk);
      if (expq.size() == 0) break;
      dec_ready = (mode == 0) ? 1'b1 : ((i % 3) != 1);
      i++;
    end
    dec_ready = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    mem_rdy = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend.size() > 0 && pend[0].due <= cyc) begin
        mem_rvalid = 1'b1;
        mem_rdata  = word(pend[0].a);
        void'(pend.pop_front());
      end else begin
        mem_rvalid = 1'b0;
      end
      mem_rdy = rst_n && (budget > 0) && ((cyc % 4) != 3);
      #2;
      if (mem_req && mem_rdy) begin
        pend_t p;
        chk(mem_addr == next_fa, "R2", mem_addr, next_fa);
        next_fa = next_fa + 32'd4;
        p.a = mem_addr;
        p.due = cyc + ((lat_mode == 0) ? (1 + cyc % 3) : 4);
        pend.push_back(p);
        budget--;
        acc_since++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && dec_valid && dec_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, cur_tag, dec_instr, 32'h0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(dec_wide == e.wide, e.wide ? "R5" : "R4", {31'h0, dec_wide}, {31'h0, e.wide});
          chk(dec_instr == e.ins, cur_tag, dec_instr, e.ins);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    logic [31:0] snap;
    rst_n = 1'b0; br_valid = 1'b0; br_addr = '0; dec_ready = 1'b0;
    wait_cycles(3);
    #2;
    chk(dec_valid == 1'b0, "R1", {31'h0, dec_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    push_walk(32'h0, 30);
    #1;
    chk(dec_valid == 1'b0, "R1", {31'h0, dec_valid}, 32'h0);
    chk(mem_req == 1'b1, "R1", {31'h0, mem_req}, 32'h1);
    chk(mem_addr == 32'h0, "R1", mem_addr, 32'h0);
    cur_tag = "R4";
    drain(0);

    cur_tag = "R5";
    do_branch(32'h0000_0100, 40);
    drain(1);

    cur_tag = "R3";
    do_branch(32'h0000_0400, 20);
    wait_cycles(15);
    #2;
    chk(acc_since == 3, "R3", acc_since, 32'd3);
    chk(mem_req == 1'b0, "R3", {31'h0, mem_req}, 32'h0);
    chk(dec_valid == 1'b1, "R10", {31'h0, dec_valid}, 32'h1);
    snap = dec_instr;
    wait_cycles(3);
    #2;
    chk(dec_valid == 1'b1 && dec_instr == snap, "R10", dec_instr, snap);
    drain(1);

    cur_tag = "R9";
    do_branch(32'h0000_0600, 10);
    wait_cycles(10);
    do_branch(32'h0000_0700, 25);
    drain(0);

    cur_tag = "R8";
    a = 32'h0000_0802;
    while (is_wide(hw(a))) a = a + 32'd4;
    do_branch(a, 20);
    wait_cycles(10);
    #2;
    chk(dec_valid == 1'b1 && dec_instr == {16'h0, hw(a)}, "R8", dec_instr, {16'h0, hw(a)});
    drain(1);

    cur_tag = "R6";
    a = 32'h0000_0a02;
    while (!is_wide(hw(a))) a = a + 32'd4;
    budget = 0;
    do_branch(a, 20);
    budget = 1;
    wait_cycles(10);
    #2;
    chk(dec_valid == 1'b0, "R6", {31'h0, dec_valid}, 32'h0);
    budget = 1;
    wait_cycles(10);
    #2;
    chk(dec_valid == 1'b1 && dec_wide == 1'b1, "R6", {30'h0, dec_valid, dec_wide}, 32'h3);
    chk(dec_instr == {hw(a), hw(a + 32'd2)}, "R6", dec_instr, {hw(a), hw(a + 32'd2)});
    budget = 1000000;
    drain(0);

    cur_tag = "R7";
    lat_mode = 1;
    do_branch(32'h0000_0c00, 10);
    wait_cycles(2);
    do_branch(32'h0000_0e06, 30);
    drain(1);
    do_branch(32'h0000_1000, 5);
    do_branch(32'h0000_1200, 30);
    drain(0);
    lat_mode = 0;

    wait_cycles(5);
    finish_run();
  end
endmodule